// File: doc/BRIEF.md
# CEA Extension HDMI Capability Scanner

This block inspects one 128-byte display-capability extension block and decides whether the attached sink is an HDMI device and, if so, whether it supports basic audio. The extension sits in a byte-addressable buffer with a combinational read port. The scanner drives the read address and consumes one byte per clock.

A one-cycle `start` pulse begins a scan. The scanner first checks the extension tag and then reads the end offset of the data block collection. It then walks the chain of length-prefixed data blocks, starting at offset 4. For each block it checks that the block fits inside the collection. It looks for a vendor-specific block that carries the three-byte HDMI registration identifier. When it finds that block, it reads the basic-audio flag from the extension header. A single-cycle `done` pulse closes the scan. `hdmi_found` and `audio_supported` then stay valid until the next accepted start.

Top module: `cea_vsdb_scan`

## Requirements
- R1: A scan whose byte 0 is not 0x02 ends after that single read with hdmi_found=0 and audio_supported=0.
- R2: Byte 2 is the collection end offset. When it is 4 or less, the scan ends with hdmi_found=0 and no header is read.
- R3: Headers are walked from offset 4. Each header holds a tag in bits 7:5 and a payload length in bits 4:0. The next header lies at position + 1 + length, and an unrelated block is skipped without changing the result.
- R4: A block matches when its tag is 3, its length is at least 5, and its next three bytes are 0x03, 0x0C and 0x00 in that order. A shorter block or a partial identifier does not match, and the walk continues after it.
- R5: When position + length + 1 of a header exceeds the end offset, the scan stops with hdmi_found=0, even if the block would otherwise match.
- R6: On a match, audio_supported equals bit 6 of byte 3. audio_supported is never 1 while hdmi_found is 0.
- R7: Results are cleared when a start is accepted. They then hold steady until the following accepted start, whatever the buffer holds in between. A start while busy is ignored.
- R8: The block reads one byte per cycle. busy is high from the cycle after the accepting edge until done. done is a one-cycle pulse, raised exactly once per scan, n cycles after the accepting edge, where n is the number of bytes read.
- R9: An end offset above 128 is treated as 128. When the next header position reaches the end offset, the scan ends with hdmi_found=0. A chain of zero-length blocks therefore ends after at most 124 header steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan; ignored while busy |
| rd_addr | output | 7 | Byte address into the extension buffer |
| rd_data | input | 8 | Byte at rd_addr, available in the same cycle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| hdmi_found | output | 1 | HDMI vendor block found in the last scan |
| audio_supported | output | 1 | Basic audio flag from the last successful scan |

## Verification
Every result falls due a fixed number of cycles after the accepting start edge. That number is the count of bytes the scan reads: the tag, the end offset, each header, each identifier byte compared, and the flag byte on a match. done, hdmi_found and audio_supported all change at that same edge. The bench's reference model works out that byte count from the buffer contents as each start is accepted. It then counts edges down to zero. On every falling edge it compares the model's done, busy and results with the design's, so that an early, late or repeated done shows up in the exact cycle where it occurs. Each scenario also ends with checks against values worked out by hand.

// File: rtl/cea_scan_pkg.sv
package cea_scan_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG,
    S_END,
    S_HDR,
    S_ID,
    S_AUD
  } scan_state_t;

  // header byte: tag in the top three bits, payload length in the low five
  function automatic logic [2:0] hdr_tag(input logic [7:0] b);
    return b[7:5];
  endfunction

  function automatic logic [4:0] hdr_len(input logic [7:0] b);
    return b[4:0];
  endfunction

  // position of the header that follows a block
  function automatic int next_hdr(input int pos, input int len);
    return pos + 1 + len;
  endfunction

  // end offset limited to the buffer size
  function automatic int clamp_end(input int raw, input int lim);
    return (raw > lim) ? lim : raw;
  endfunction

endpackage

// File: rtl/cea_hdr_decode.sv
module cea_hdr_decode
  import cea_scan_pkg::*;
#(
  parameter int PW           = 9,
  parameter int VSDB_TAG     = 3,
  parameter int MIN_VSDB_LEN = 5
) (
  input  logic [7:0]    hdr_byte,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] end_ofs,
  output logic [4:0]    len,
  output logic          cand,
  output logic          overrun,
  output logic [PW-1:0] nxt
);
  logic [2:0] tag;

  always_comb begin
    tag     = hdr_tag(hdr_byte);
    len     = hdr_len(hdr_byte);
    nxt     = PW'(next_hdr(int'(pos), int'(len)));
    cand    = (int'(tag) == VSDB_TAG) && (int'(len) >= MIN_VSDB_LEN);
    overrun = nxt > end_ofs;
  end
endmodule

// File: rtl/cea_id_match.sv
module cea_id_match #(
  parameter int              ID_LEN = 3,
  parameter logic [ID_LEN*8-1:0] ID_SEQ = 24'h000C03,
  localparam int             IW     = (ID_LEN > 1) ? $clog2(ID_LEN) : 1
) (
  input  logic [IW-1:0] idx,
  input  logic [7:0]    data,
  output logic          match
);
  logic [7:0] expect_b [2**IW];

  for (genvar i = 0; i < 2**IW; i++) begin : g_tab
    if (i < ID_LEN) begin : g_used
      assign expect_b[i] = ID_SEQ[i*8 +: 8];
    end else begin : g_spare
      assign expect_b[i] = 8'h00;
    end
  end

  assign match = (data == expect_b[idx]);
endmodule

// File: rtl/cea_vsdb_scan.sv
module cea_vsdb_scan
  import cea_scan_pkg::*;
#(
  parameter int BLK_BYTES    = 128,
  parameter int EXT_TAG      = 2,
  parameter int END_BYTE     = 2,
  parameter int FLAG_BYTE    = 3,
  parameter int AUD_BIT      = 6,
  parameter int FIRST_HDR    = 4,
  parameter int VSDB_TAG     = 3,
  parameter int MIN_VSDB_LEN = 5,
  parameter int ID_LEN       = 3,
  parameter logic [ID_LEN*8-1:0] ID_SEQ = 24'h000C03,
  localparam int AW = $clog2(BLK_BYTES),
  localparam int PW = AW + 2,
  localparam int IW = (ID_LEN > 1) ? $clog2(ID_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          hdmi_found,
  output logic          audio_supported
);
  scan_state_t   state, st_n;
  logic [PW-1:0] ptr, ptr_n, end_q, end_n;
  logic [4:0]    len_q, len_n;
  logic [IW-1:0] idx, idx_n;
  logic [PW-1:0] step_cnt;

  // named internal events
  logic          scan_finish;
  logic          vsdb_hit;
  logic          hdr_step;
  logic          start_ok;

  logic [4:0]    hd_len;
  logic          hd_cand, hd_overrun;
  logic [PW-1:0] hd_next, skip_next;
  logic          id_ok;

  cea_hdr_decode #(
    .PW(PW), .VSDB_TAG(VSDB_TAG), .MIN_VSDB_LEN(MIN_VSDB_LEN)
  ) u_hdr (
    .hdr_byte(rd_data), .pos(ptr), .end_ofs(end_q),
    .len(hd_len), .cand(hd_cand), .overrun(hd_overrun), .nxt(hd_next)
  );

  cea_id_match #(.ID_LEN(ID_LEN), .ID_SEQ(ID_SEQ)) u_id (
    .idx(idx), .data(rd_data), .match(id_ok)
  );

  assign busy      = (state != S_IDLE);
  assign start_ok  = (state == S_IDLE) && start;
  assign hdr_step  = (state == S_HDR);
  assign skip_next = PW'(next_hdr(int'(ptr), int'(len_q)));

  always_comb begin
    case (state)
      S_END:   rd_addr = AW'(END_BYTE);
      S_HDR:   rd_addr = ptr[AW-1:0];
      S_ID:    rd_addr = AW'(int'(ptr) + 1 + int'(idx));
      S_AUD:   rd_addr = AW'(FLAG_BYTE);
      default: rd_addr = '0;
    endcase
  end

  always_comb begin
    st_n        = state;
    ptr_n       = ptr;
    end_n       = end_q;
    len_n       = len_q;
    idx_n       = idx;
    scan_finish = 1'b0;
    vsdb_hit    = 1'b0;
    case (state)
      S_IDLE: if (start) st_n = S_TAG;
      S_TAG: begin
        if (int'(rd_data) == EXT_TAG) st_n = S_END;
        else scan_finish = 1'b1;
      end
      S_END: begin
        end_n = PW'(clamp_end(int'(rd_data), BLK_BYTES));
        ptr_n = PW'(FIRST_HDR);
        if (clamp_end(int'(rd_data), BLK_BYTES) <= FIRST_HDR) scan_finish = 1'b1;
        else st_n = S_HDR;
      end
      S_HDR: begin
        len_n = hd_len;
        idx_n = '0;
        if (hd_overrun) scan_finish = 1'b1;
        else if (hd_cand) st_n = S_ID;
        else begin
          ptr_n = hd_next;
          if (hd_next >= end_q) scan_finish = 1'b1;
        end
      end
      S_ID: begin
        if (id_ok) begin
          if (int'(idx) == ID_LEN - 1) st_n = S_AUD;
          else idx_n = idx + 1'b1;
        end else begin
          ptr_n = skip_next;
          if (skip_next >= end_q) scan_finish = 1'b1;
          else st_n = S_HDR;
        end
      end
      S_AUD: begin
        scan_finish = 1'b1;
        vsdb_hit    = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
    if (scan_finish) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      ptr             <= '0;
      end_q           <= '0;
      len_q           <= '0;
      idx             <= '0;
      done            <= 1'b0;
      hdmi_found      <= 1'b0;
      audio_supported <= 1'b0;
      step_cnt        <= '0;
    end else begin
      state <= st_n;
      ptr   <= ptr_n;
      end_q <= end_n;
      len_q <= len_n;
      idx   <= idx_n;
      done  <= scan_finish;
      if (start_ok) begin
        hdmi_found      <= 1'b0;
        audio_supported <= 1'b0;
        step_cnt        <= '0;
      end else if (hdr_step) begin
        step_cnt <= step_cnt + 1'b1;
      end
      if (vsdb_hit) begin
        hdmi_found      <= 1'b1;
        audio_supported <= rd_data[AUD_BIT];
      end
    end
  end

  // R8: done lasts one cycle and leaves the scanner idle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: audio is reported only together with a match
  a_r6_audio_needs_found: assert property (@(posedge clk) disable iff (!rst_n)
    audio_supported |-> hdmi_found);
  // R7: results hold while idle and no start arrives
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hdmi_found) && $stable(audio_supported)));
  // R5: every header read lies inside the collection
  a_r5_hdr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_step |-> (ptr < end_q));
  // R9: header steps per scan stay within the buffer size
  a_r9_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_cnt) <= BLK_BYTES);
endmodule

// File: tb/cea_vsdb_scan_tb.sv
module cea_vsdb_scan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       busy, done, hdmi_found, audio_supported;
  logic [7:0] mem [0:127];

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  assign rd_data = mem[rd_addr];

  cea_vsdb_scan u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done),
    .hdmi_found(hdmi_found), .audio_supported(audio_supported)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // behavioural reference: result and byte count of one scan
  function automatic void ref_scan(output bit f, output bit a, output int n);
    int e, p, t, l;
    f = 0; a = 0; n = 1;
    if (mem[0] != 8'h02) return;
    n++;
    e = mem[2];
    if (e > 128) e = 128;
    if (e <= 4) return;
    p = 4;
    while (p < e) begin
      n++;
      t = mem[p] / 32;
      l = mem[p] % 32;
      if (p + l + 1 > e) return;
      if (t == 3 && l >= 5) begin
        n++;
        if (mem[p+1] == 8'h03) begin
          n++;
          if (mem[p+2] == 8'h0C) begin
            n++;
            if (mem[p+3] == 8'h00) begin
              n++;
              f = 1;
              a = mem[3][6];
              return;
            end
          end
        end
      end
      p = p + 1 + l;
    end
  endfunction

  bit m_busy, m_done, m_found, m_aud, rf, ra;
  int m_cnt, rn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_found = 0; m_aud = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_found = rf; m_aud = ra;
        end
      end else if (start) begin
        ref_scan(rf, ra, rn);
        m_cnt = rn; m_busy = 1; m_found = 0; m_aud = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R8 done timing", int'(done), int'(m_done));
      chk("R8 busy window", int'(busy), int'(m_busy));
      chk("R7 found vs model", int'(hdmi_found), int'(m_found));
      chk("R6 audio vs model", int'(audio_supported), int'(m_aud));
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
  endtask

  task automatic put_vsdb(input int p, input int len);
    mem[p] = 8'(96 + len);
    mem[p+1] = 8'h03; mem[p+2] = 8'h0C; mem[p+3] = 8'h00;
  endtask

  task automatic run_scan(input string req, input bit ef, input bit ea,
                          input bit extra_start);
    int dones = 0;
    int cyc = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 400) begin
      if (extra_start && cyc == 3) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (done) dones++;
    chk({req, " result found"}, int'(hdmi_found), int'(ef));
    chk({req, " result audio"}, int'(audio_supported), int'(ea));
    repeat (3) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R8 one done per scan", dones, 1);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R7 reset found", int'(hdmi_found), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    running = 1'b1;

    // R1: wrong extension tag
    clear_mem(); mem[0] = 8'h03; mem[2] = 8'd10; put_vsdb(4, 5); mem[3] = 8'h40;
    run_scan("R1", 0, 0, 0);

    // R2: end offset 4, then 3
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd4; put_vsdb(4, 5);
    run_scan("R2 end=4", 0, 0, 0);
    mem[2] = 8'd3;
    run_scan("R2 end=3", 0, 0, 0);

    // R4 R6: first block matches, audio bit set
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd10; mem[3] = 8'h40; put_vsdb(4, 5);
    run_scan("R4 R6 audio on", 1, 1, 0);

    // R3: skip an unrelated block, match second, audio clear
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd15; mem[3] = 8'hBF;
    mem[4] = 8'h43; mem[5] = 8'h03; mem[6] = 8'h0C; mem[7] = 8'h00;
    put_vsdb(8, 6);
    run_scan("R3 R6 audio off", 1, 0, 0);

    // R4: too short a block
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd9; mem[3] = 8'h40; put_vsdb(4, 4);
    run_scan("R4 short", 0, 0, 0);

    // R4: partial identifier, then a real one
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd16; mem[3] = 8'h40;
    put_vsdb(4, 5); mem[7] = 8'h01; put_vsdb(10, 5);
    run_scan("R4 partial id", 1, 1, 0);

    // R7: results stay while buffer changes and no start comes
    clear_mem();
    repeat (20) @(negedge clk);
    chk("R7 hold found", int'(hdmi_found), 1);
    chk("R7 hold audio", int'(audio_supported), 1);
    mem[0] = 8'h05;
    run_scan("R7 cleared on restart", 0, 0, 0);

    // R5: otherwise valid block overruns end
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd9; mem[3] = 8'h40; put_vsdb(4, 5);
    run_scan("R5 overrun", 0, 0, 0);

    // R9: zero-length chain to end
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd40;
    run_scan("R9 zero chain", 0, 0, 0);

    // R7 R8: start while busy is ignored
    run_scan("R7 start while busy", 0, 0, 1);

    // R9: end offset 200 clamps to 128, so a block at 124 overruns
    clear_mem(); mem[0] = 8'h02; mem[2] = 8'd200; mem[3] = 8'h40; put_vsdb(124, 5);
    run_scan("R9 clamp", 0, 0, 0);

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule